// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block decides when a simple processor model takes an interrupt, and it runs the entry and return sequences around that decision. Seven request lines carry priority levels one to seven. A 3-bit mask inside the block's 16-bit status word blocks every maskable level at or below its value. The top level cannot be masked, and it is taken once for each rising edge of its line.

When a request is taken, the block sets the supervisor flag and raises the mask to the level it accepted. It then writes the old status word and the interrupted program counter below a supervisor stack pointer that it keeps itself. Next it acknowledges the level and looks up the handler address in a vector table at address zero, using 4-byte entries. The entry number is either a fixed autovector slot for the level or a vector number that the requester drives on an 8-bit bus.

A return command reverses the sequence. It reads the program counter back and then the status word, which restores the mask and the privilege flag. Decisions are made only while the block is idle, which stands for the gap between instructions. The memory port completes a read in the cycle it is issued.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the status word is 0x2700: supervisor flag at bit 13, mask in bits 10:8 equal to 7. The stack pointer equals SSP_INIT. While `busy` is low, `mem_we`, `mem_re`, `mem_long`, `pc_load` and `take_done` are low, and `mem_addr`, `mem_wdata`, `pc_val` and `iack_level` are zero.
- R2: A pending level from 1 to 6 is taken only when it is strictly greater than the current mask. A level equal to or below the mask leaves the block idle.
- R3: Bit i of `irq_req` requests level i+1. When several levels are pending, only the highest one is weighed against the mask.
- R4: Level 7 is taken even when the mask is 7. A rise of its line is latched at the first clock edge where the line is seen high, and it can be taken from the next idle cycle. A line held high is taken only once, until it falls and rises again.
- R5: In the cycle after acceptance the block writes the pre-acceptance status word as a 2-byte write (`mem_long`=0) at SP-2. In the next cycle it writes the saved program counter as a 4-byte write at SP-6. The stack pointer ends 6 lower.
- R6: From the cycle after acceptance, `sr_out` has bit 13 set and bits 10:8 equal to the accepted level. All other bits are unchanged.
- R7: In the third cycle after acceptance, `iack_level` shows the accepted level. In the fourth cycle the block issues a 4-byte read at 0x60+4*level when `irq_autovec` was high in the third cycle, or at 4*`irq_vec_num` otherwise. In that same cycle `pc_load` and `take_done` pulse, and `pc_val` equals `mem_rdata`.
- R8: A return command taken while idle reads 4 bytes at SP in the next cycle and presents them on `pc_val` with `pc_load`. In the following cycle it reads 2 bytes at SP+4 and loads `mem_rdata[15:0]` into the status word. The stack pointer ends 6 higher.
- R9: When a return command and an acceptable request fall in the same idle cycle, the return runs first. The request is then judged against the restored mask.
- R10: `sr_load` replaces the status word only in an idle cycle with no return command and no acceptance. Outside such a cycle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 7 | Request lines, bit i = level i+1 |
| irq_autovec | input | 1 | Requester asks for the fixed per-level table slot |
| irq_vec_num | input | 8 | Vector number supplied by the requester |
| rte_cmd | input | 1 | Return-from-exception command |
| sr_load | input | 1 | Write strobe for the status word |
| sr_din | input | 16 | New status word value |
| pc_in | input | 32 | Program counter of the interrupted flow |
| mem_rdata | input | 32 | Read data, valid in the cycle of the read |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_long | output | 1 | Access size: 1 = 4 bytes, 0 = 2 bytes |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data (2-byte writes in bits 15:0) |
| iack_level | output | 3 | Accepted level during the acknowledge cycle, else 0 |
| pc_load | output | 1 | Program counter load strobe |
| pc_val | output | 32 | Value to load into the program counter |
| take_done | output | 1 | Pulses when the handler address is loaded |
| sr_out | output | 16 | Current status word |
| busy | output | 1 | A sequence is in progress |

## Verification
The return command and an interrupt acceptance can both be due in the same idle cycle, and the bench provokes this directly. It first takes level 3 from mask 0. From inside that handler it raises level 4 in the very cycle the return is issued. Level 4 would pass the mask on its own, so the outcome shows which one won. The reference model orders the return first, so the bench expects the new status push at the original stack slot, holding the restored value 0x2000, and expects the fetch at the level-4 autovector. A design that let the interrupt win would nest the frame six bytes lower with mask 3 in the saved word.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int LVL_W   = 3;
  localparam int NREQ    = 7;
  localparam int SR_W    = 16;
  localparam int ADDR_W  = 32;
  localparam int VEC_W   = 8;
  localparam int SUP_BIT = 13;
  localparam int MASK_LO = 8;
  localparam int SR_BYTES = 2;
  localparam int PC_BYTES = 4;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NREQ);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_SR, S_PUSH_PC, S_VECTOR, S_FETCH, S_POP_PC, S_POP_SR
  } seq_e;

  // highest asserted request, encoded as level (bit i -> level i+1)
  function automatic logic [LVL_W-1:0] top_level(input logic [NREQ-1:0] r);
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = 0; i < NREQ; i++)
      if (r[i]) l = LVL_W'(i + 1);
    return l;
  endfunction

  function automatic logic [LVL_W-1:0] sr_mask(input logic [SR_W-1:0] sr);
    return sr[MASK_LO +: LVL_W];
  endfunction

  // maskable levels must exceed the mask; the top level always passes
  function automatic logic level_passes(input logic [LVL_W-1:0] lvl,
                                        input logic [LVL_W-1:0] mask);
    return (lvl == TOP_LVL) || (lvl > mask);
  endfunction

  function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] sr,
                                               input logic [LVL_W-1:0] lvl);
    logic [SR_W-1:0] s;
    s = sr;
    s[SUP_BIT] = 1'b1;
    s[MASK_LO +: LVL_W] = lvl;
    return s;
  endfunction

  // vector table entry address: entry number times four
  function automatic logic [ADDR_W-1:0] table_addr(input logic auto_sel,
                                                   input logic [LVL_W-1:0] lvl,
                                                   input logic [VEC_W-1:0] vnum,
                                                   input logic [VEC_W-1:0] auto_base);
    logic [VEC_W-1:0] v;
    v = auto_sel ? (auto_base + VEC_W'(lvl)) : vnum;
    return {{(ADDR_W-VEC_W-2){1'b0}}, v, 2'b00};
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req,
  input  logic [LVL_W-1:0] mask,
  input  logic             idle,
  input  logic             rte,
  output logic             take,
  output logic [LVL_W-1:0] take_lvl
);

  logic top_q, top_pend;
  logic top_rise;
  logic [NREQ-1:0] eff_req;
  logic [LVL_W-1:0] cand;

  assign top_rise = req[NREQ-1] & ~top_q;
  assign eff_req  = {top_pend, req[NREQ-2:0]};
  assign cand     = top_level(eff_req);
  assign take     = idle & ~rte & (cand != '0) & level_passes(cand, mask);
  assign take_lvl = cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q    <= 1'b0;
      top_pend <= 1'b0;
    end else begin
      top_q    <= req[NREQ-1];
      top_pend <= (top_pend & ~(take && cand == TOP_LVL)) | top_rise;
    end
  end

  // R3: an accepted level is never below a raw maskable request
  p_highest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_lvl >= top_level({1'b0, req[NREQ-2:0]})));

endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_pkg::*;
#(
  parameter logic [SR_W-1:0] SR_INIT = 16'h2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             rte,
  input  logic             take,
  input  logic [LVL_W-1:0] take_lvl,
  input  logic             restore,
  input  logic [SR_W-1:0]  restore_sr,
  input  logic             sr_load,
  input  logic [SR_W-1:0]  sr_din,
  output logic [SR_W-1:0]  sr
);

  logic load_ok;
  assign load_ok = idle & ~rte & ~take & sr_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= SR_INIT;
    else if (take)    sr <= sr_enter(sr, take_lvl);
    else if (restore) sr <= restore_sr;
    else if (load_ok) sr <= sr_din;
  end

  // R10: nothing but the restore step moves the word during a sequence
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !restore) |=> $stable(sr));

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SSP_INIT  = 32'h0000_1000,
  parameter logic [VEC_W-1:0]  AUTO_BASE = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LVL_W-1:0]  take_lvl,
  input  logic              rte,
  input  logic [SR_W-1:0]   sr_cur,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              autovec,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              idle,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic              mem_long,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  output logic [LVL_W-1:0]  iack_level,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_val,
  output logic              take_done,
  output logic              restore,
  output logic [SR_W-1:0]   restore_sr
);

  localparam logic [ADDR_W-1:0] SR_STEP = ADDR_W'(SR_BYTES);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(PC_BYTES);

  seq_e state;
  logic [ADDR_W-1:0] ssp, pc_save, vaddr;
  logic [SR_W-1:0]   old_sr;
  logic [LVL_W-1:0]  lvl;

  assign idle = (state == S_IDLE);
  assign busy = ~idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ssp     <= SSP_INIT;
      pc_save <= '0;
      vaddr   <= '0;
      old_sr  <= '0;
      lvl     <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (rte) state <= S_POP_PC;
          else if (take) begin
            lvl     <= take_lvl;
            old_sr  <= sr_cur;
            pc_save <= pc_in;
            state   <= S_PUSH_SR;
          end
        end
        S_PUSH_SR: begin ssp <= ssp - SR_STEP; state <= S_PUSH_PC; end
        S_PUSH_PC: begin ssp <= ssp - PC_STEP; state <= S_VECTOR;  end
        S_VECTOR: begin
          vaddr <= table_addr(autovec, lvl, vec_num, AUTO_BASE);
          state <= S_FETCH;
        end
        S_FETCH:  state <= S_IDLE;
        S_POP_PC: begin ssp <= ssp + PC_STEP; state <= S_POP_SR; end
        S_POP_SR: begin ssp <= ssp + SR_STEP; state <= S_IDLE;   end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    mem_long   = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    iack_level = '0;
    pc_load    = 1'b0;
    take_done  = 1'b0;
    restore    = 1'b0;
    unique case (state)
      S_PUSH_SR: begin
        mem_we    = 1'b1;
        mem_addr  = ssp - SR_STEP;
        mem_wdata = ADDR_W'(old_sr);
      end
      S_PUSH_PC: begin
        mem_we    = 1'b1;
        mem_long  = 1'b1;
        mem_addr  = ssp - PC_STEP;
        mem_wdata = pc_save;
      end
      S_VECTOR: iack_level = lvl;
      S_FETCH: begin
        mem_re    = 1'b1;
        mem_long  = 1'b1;
        mem_addr  = vaddr;
        pc_load   = 1'b1;
        take_done = 1'b1;
      end
      S_POP_PC: begin
        mem_re   = 1'b1;
        mem_long = 1'b1;
        mem_addr = ssp;
        pc_load  = 1'b1;
      end
      S_POP_SR: begin
        mem_re   = 1'b1;
        mem_addr = ssp;
        restore  = 1'b1;
      end
      default: ;
    endcase
  end

  assign pc_val     = pc_load ? mem_rdata : '0;
  assign restore_sr = mem_rdata[SR_W-1:0];

  // R5: the 2-byte status push is followed by a 4-byte push four bytes lower
  p_push_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_long) |=> (mem_we && mem_long && mem_addr == $past(mem_addr) - PC_STEP));

  // R7: the acknowledge cycle is followed by the handler load
  p_ack_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_level != '0) |=> (take_done && pc_load && mem_re));

  // R8: the counter pop is followed by the status pop four bytes higher
  p_pop_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_long && !take_done) |=> (mem_re && !mem_long && mem_addr == $past(mem_addr) + PC_STEP));

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SSP_INIT  = 32'h0000_1000,
  parameter logic [SR_W-1:0]   SR_INIT   = 16'h2700,
  parameter logic [VEC_W-1:0]  AUTO_BASE = 8'h18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [6:0]   irq_req,
  input  logic         irq_autovec,
  input  logic [7:0]   irq_vec_num,
  input  logic         rte_cmd,
  input  logic         sr_load,
  input  logic [15:0]  sr_din,
  input  logic [31:0]  pc_in,
  input  logic [31:0]  mem_rdata,
  output logic         mem_we,
  output logic         mem_re,
  output logic         mem_long,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  output logic [2:0]   iack_level,
  output logic         pc_load,
  output logic [31:0]  pc_val,
  output logic         take_done,
  output logic [15:0]  sr_out,
  output logic         busy
);

  logic             idle, take, restore;
  logic [LVL_W-1:0] take_lvl;
  logic [SR_W-1:0]  restore_sr;

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .mask(sr_mask(sr_out)),
    .idle(idle), .rte(rte_cmd), .take(take), .take_lvl(take_lvl)
  );

  irq_status #(.SR_INIT(SR_INIT)) u_sr (
    .clk(clk), .rst_n(rst_n), .idle(idle), .rte(rte_cmd), .take(take),
    .take_lvl(take_lvl), .restore(restore), .restore_sr(restore_sr),
    .sr_load(sr_load), .sr_din(sr_din), .sr(sr_out)
  );

  irq_sequencer #(.SSP_INIT(SSP_INIT), .AUTO_BASE(AUTO_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(take_lvl), .rte(rte_cmd),
    .sr_cur(sr_out), .pc_in(pc_in), .autovec(irq_autovec), .vec_num(irq_vec_num),
    .mem_rdata(mem_rdata), .idle(idle), .busy(busy), .mem_we(mem_we),
    .mem_re(mem_re), .mem_long(mem_long), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .iack_level(iack_level), .pc_load(pc_load),
    .pc_val(pc_val), .take_done(take_done), .restore(restore),
    .restore_sr(restore_sr)
  );

  // R6: acceptance sets supervisor state and lifts the mask to the level
  p_mask_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sr_out[SUP_BIT] && sr_mask(sr_out) == $past(take_lvl)));

  // R2: a maskable level that is taken lies above the mask of the status module
  p_mask_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl != TOP_LVL) |-> (take_lvl > sr_out[MASK_LO +: LVL_W]));

  // R1: no memory traffic or acknowledge while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && iack_level == '0 && !pc_load));

endmodule

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  irq_req;
  logic        irq_autovec;
  logic [7:0]  irq_vec_num;
  logic        rte_cmd, sr_load;
  logic [15:0] sr_din;
  logic [31:0] pc_in, mem_rdata;
  logic        mem_we, mem_re, mem_long, pc_load, take_done, busy;
  logic [31:0] mem_addr, mem_wdata, pc_val;
  logic [2:0]  iack_level;
  logic [15:0] sr_out;

  always #10 clk = ~clk;   // 50 MHz

  irq_accept_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_autovec(irq_autovec),
    .irq_vec_num(irq_vec_num), .rte_cmd(rte_cmd), .sr_load(sr_load),
    .sr_din(sr_din), .pc_in(pc_in), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_long(mem_long), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .iack_level(iack_level), .pc_load(pc_load),
    .pc_val(pc_val), .take_done(take_done), .sr_out(sr_out), .busy(busy)
  );

  int vectors = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory: unwritten table slots hold 0x4000_0000 + address
  logic [31:0] mem [int];
  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h4000_0000 | a;
  endfunction

  always @(posedge clk) begin
    #1;
    mem_rdata = rd(mem_addr);
  end

  // behavioural reference model
  int ph;
  logic [15:0] m_sr, m_old;
  logic [31:0] m_ssp, m_pc, m_vaddr, m_tmp;
  logic [2:0]  m_lvl;
  logic        l7p, l7prev, rise_now;
  logic [6:0]  eff;
  int          best;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_sr = 16'h2700; m_ssp = 32'h1000; l7p = 0; l7prev = 0;
      m_lvl = 0; m_old = 0; m_pc = 0; m_vaddr = 0;
    end else begin
      eff = {l7p, irq_req[5:0]};
      best = 0;
      for (int i = 0; i < 7; i++) if (eff[i]) best = i + 1;
      rise_now = irq_req[6] && !l7prev;
      l7prev = irq_req[6];
      case (ph)
        0: begin
          if (rte_cmd) ph = 11;
          else if (best != 0 && (best == 7 || best > int'(m_sr[10:8]))) begin
            m_lvl = 3'(best); m_old = m_sr; m_pc = pc_in;
            m_sr[13] = 1'b1; m_sr[10:8] = 3'(best); ph = 1;
            if (best == 7) l7p = 0;
          end else if (sr_load) m_sr = sr_din;
        end
        1: begin mem[int'(m_ssp - 2)] = {16'h0, m_old}; m_ssp = m_ssp - 2; ph = 2; end
        2: begin mem[int'(m_ssp - 4)] = m_pc; m_ssp = m_ssp - 4; ph = 3; end
        3: begin
          m_vaddr = irq_autovec ? 32'(96 + 4 * int'(m_lvl)) : 32'(4 * int'(irq_vec_num));
          ph = 4;
        end
        4: ph = 0;
        11: begin m_ssp = m_ssp + 4; ph = 12; end
        12: begin m_tmp = rd(m_ssp); m_sr = m_tmp[15:0]; m_ssp = m_ssp + 2; ph = 0; end
        default: ph = 0;
      endcase
      if (rise_now) l7p = 1'b1;
    end
  end

  // per-cycle comparison, away from the active edge
  logic        e_we, e_re, e_long, e_pcl, e_done;
  logic [31:0] e_addr, e_wdata, e_pcv;
  logic [2:0]  e_ack;
  string       tg;

  always @(negedge clk) begin
    if (rst_n) begin
      e_we = 0; e_re = 0; e_long = 0; e_pcl = 0; e_done = 0;
      e_addr = 0; e_wdata = 0; e_pcv = 0; e_ack = 0; tg = "R1";
      case (ph)
        1: begin tg = "R5"; e_we = 1; e_addr = m_ssp - 2; e_wdata = {16'h0, m_old}; end
        2: begin tg = "R5"; e_we = 1; e_long = 1; e_addr = m_ssp - 4; e_wdata = m_pc; end
        3: begin tg = "R7"; e_ack = m_lvl; end
        4: begin tg = "R7"; e_re = 1; e_long = 1; e_addr = m_vaddr; e_pcl = 1; e_done = 1; e_pcv = rd(m_vaddr); end
        11: begin tg = "R8"; e_re = 1; e_long = 1; e_addr = m_ssp; e_pcl = 1; e_pcv = rd(m_ssp); end
        12: begin tg = "R8"; e_re = 1; e_addr = m_ssp; end
        default: ;
      endcase
      chk({tg, " we"}, 32'(mem_we), 32'(e_we));
      chk({tg, " re"}, 32'(mem_re), 32'(e_re));
      chk({tg, " long"}, 32'(mem_long), 32'(e_long));
      chk({tg, " addr"}, mem_addr, e_addr);
      chk({tg, " wdata"}, mem_wdata, e_wdata);
      chk({tg, " ack"}, 32'(iack_level), 32'(e_ack));
      chk({tg, " pc_load"}, 32'(pc_load), 32'(e_pcl));
      chk({tg, " pc_val"}, pc_val, e_pcv);
      chk({tg, " done"}, 32'(take_done), 32'(e_done));
      chk("R1 busy", 32'(busy), 32'(ph != 0));
      chk("R6 sr", 32'(sr_out), 32'(m_sr));
    end
  end

  // observed events
  int          takes = 0;
  logic [31:0] last_fetch = 0, last_pc = 0, push_sr_addr = 0, push_sr_val = 0, push_pc_val = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (take_done) begin takes++; last_fetch = mem_addr; end
      if (pc_load) last_pc = pc_val;
      if (mem_we && !mem_long) begin push_sr_addr = mem_addr; push_sr_val = mem_wdata; end
      if (mem_we && mem_long) push_pc_val = mem_wdata;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_sr(input logic [15:0] v);
    sr_load = 1; sr_din = v; cyc(1); sr_load = 0;
  endtask

  task automatic do_rte();
    rte_cmd = 1; cyc(1); rte_cmd = 0; cyc(5);
  endtask

  int t0;

  initial begin
    rst_n = 0; irq_req = 0; irq_autovec = 1; irq_vec_num = 0; rte_cmd = 0;
    sr_load = 0; sr_din = 0; pc_in = 32'h0000_2000; mem_rdata = 0;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 reset sr", 32'(sr_out), 32'h2700);
    chk("R1 reset busy", 32'(busy), 0);

    // R2: level 3 against mask 7 is blocked
    irq_req = 7'b0000100; cyc(5);
    chk("R2 masked level ignored", 32'(takes), 0);
    irq_req = 0;

    // R3: levels 2 and 5 pending with mask 0
    load_sr(16'h2000);
    pc_in = 32'h1234_5670; irq_req = 7'b0010010; cyc(8);
    chk("R3 highest level vector", last_fetch, 32'h74);
    chk("R6 status after entry", 32'(sr_out), 32'h2500);
    chk("R5 pushed status", push_sr_val, 32'h2000);
    chk("R5 status slot", push_sr_addr, 32'hFFE);
    chk("R5 pushed counter", push_pc_val, 32'h1234_5670);
    t0 = takes; cyc(4);
    chk("R2 equal level blocked", 32'(takes), 32'(t0));
    irq_req = 0;
    do_rte();
    chk("R8 restored status", 32'(sr_out), 32'h2000);
    chk("R8 restored counter", last_pc, 32'h1234_5670);

    // R7: supplied vector number
    load_sr(16'h2100);
    irq_autovec = 0; irq_vec_num = 8'h40; irq_req = 7'b0000010; cyc(8);
    chk("R7 vector number fetch", last_fetch, 32'h100);
    chk("R7 handler address", last_pc, 32'h4000_0100);
    irq_req = 0; do_rte();

    // R7 autovector level 2, R10 load during sequence ignored
    irq_autovec = 1; irq_req = 7'b0000010; cyc(2);
    sr_load = 1; sr_din = 16'h0000; cyc(1); sr_load = 0; cyc(6);
    chk("R7 level 2 autovector", last_fetch, 32'h68);
    chk("R10 load while busy ignored", 32'(sr_out), 32'h2200);
    irq_req = 0; do_rte();
    chk("R8 mask back to 1", 32'(sr_out), 32'h2100);

    // R4: level 7 with mask 7, held line taken once
    load_sr(16'h2700);
    t0 = takes; irq_req = 7'b1000000; cyc(8);
    chk("R4 unmaskable taken", 32'(takes), 32'(t0 + 1));
    chk("R4 level 7 vector", last_fetch, 32'h7C);
    chk("R4 mask stays 7", 32'(sr_out), 32'h2700);
    do_rte(); cyc(4);
    chk("R4 held line not retaken", 32'(takes), 32'(t0 + 1));
    irq_req = 0; cyc(2); irq_req = 7'b1000000; cyc(8);
    chk("R4 new rise taken", 32'(takes), 32'(t0 + 2));
    irq_req = 0; do_rte();

    // R9: return and acceptable request in the same cycle
    load_sr(16'h2000);
    irq_req = 7'b0000100; cyc(8); irq_req = 0;
    chk("R9 setup mask 3", 32'(sr_out), 32'h2300);
    t0 = takes;
    rte_cmd = 1; irq_req = 7'b0001000; cyc(1); rte_cmd = 0; cyc(12);
    chk("R9 request after return", 32'(takes), 32'(t0 + 1));
    chk("R9 level 4 vector", last_fetch, 32'h70);
    chk("R9 frame at original slot", push_sr_addr, 32'hFFE);
    chk("R9 restored mask pushed", push_sr_val, 32'h2000);
    irq_req = 0; do_rte();
    chk("R8 final status", 32'(sr_out), 32'h2000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule